// File: doc/BRIEF.md
# Orthogonal Effective Address Generator

This block turns a decoded addressing mode, an instruction operand and a snapshot of the index, program-counter and stack-pointer registers into a 16-bit effective address for an 8-bit processor core. Every mode is offered in combination with either index register, and indirect modes can apply the index before or after the pointer is read. Zero-page pointers, pre-indexed and post-indexed, are available with both X and Y. Absolute pointers can be pre-indexed with either register, and a plain absolute pointer can be used by data instructions as well as by jumps. Two signed relative modes add an 8-bit offset to the address of the next instruction or to the stack pointer.

The sequencer starts an address calculation with a single-cycle `start` strobe. Direct modes finish one cycle later. Indirect modes read a 16-bit little-endian pointer through a request/acknowledge byte-read port and then apply any post-index. A one-cycle `done` pulse marks the point where `ea` holds the result. The result stays on `ea` until the next accepted request.

Top module: `oea_unit`

## Requirements
- R1: After reset `done`, `mem_req` and `busy` are all 0.
- R2: Mode codes 0 (absolute), 1 (absolute+X) and 2 (absolute+Y) give the operand plus the zero-extended index, modulo 2^16. `done` rises one cycle after `start` is taken, and no memory request is made.
- R3: Mode codes 3 (zero page), 4 (zero page+X) and 5 (zero page+Y) use only operand bits 7:0. They add the index modulo 256, so the result always lies in 0x0000..0x00FF.
- R4: Mode code 14 (PC-relative) gives `pc_next` plus the sign-extended operand bits 7:0, modulo 2^16. An offset of 0xFE gives `pc_next` minus 2.
- R5: Mode code 15 (stack-relative) gives 0x0100 + `sp_reg` + sign-extended operand bits 7:0, modulo 2^16.
- R6: Indirect modes read the low pointer byte first and then the high byte. The result is {high, low} plus any post-index. For mode code 6 (absolute pointer) the bytes come from the operand and the operand+1, modulo 2^16.
- R7: For zero-page pointers the address of the high byte wraps inside page zero, so a pointer at 0x00FF takes its high byte from 0x0000.
- R8: Pre-indexed pointers add the index to the pointer location before any read. Mode codes 7/8 add X/Y to the 16-bit operand, modulo 2^16. Mode codes 10/11 add X/Y to the zero-page operand, modulo 256.
- R9: Mode codes 12/13 read the zero-page pointer named by operand bits 7:0 (mode 9 with no index) and then add X/Y to it, modulo 2^16.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req` and `mem_addr` stay unchanged. `done` is high for exactly one cycle per request, and it rises in the cycle after the acknowledge of the high byte.
- R11: `start` is ignored while `busy` is high. Mode, operand and register inputs are sampled only in the cycle in which `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (taken when not busy) |
| mode | input | 4 | Addressing mode code |
| operand | input | 16 | Instruction operand (8-bit modes use bits 7:0) |
| x_reg | input | 8 | X index register |
| y_reg | input | 8 | Y index register |
| pc_next | input | 16 | Address of the byte after the instruction |
| sp_reg | input | 8 | Stack pointer (page 1 implied) |
| mem_req | output | 1 | Pointer-byte read request |
| mem_addr | output | 16 | Pointer-byte address |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle pulse: `ea` is valid |
| ea | output | 16 | Effective address |
| busy | output | 1 | A calculation is in progress |

## Verification
The assertions assume that the memory port acknowledges only while a request is pending, and that it returns data in the same cycle as the acknowledge. The bench's memory responder runs on the falling edge and raises `mem_ack` only after it has seen `mem_req`, with a programmable number of wait cycles. The read data is a fixed function of the address, so every expected pointer value is known beforehand. Between runs, `start` is pulsed only when the block is idle, except in one scenario that deliberately strobes it while the block is busy.

// File: rtl/oea_pkg.sv
package oea_pkg;
  localparam int unsigned EA_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    AM_ABS    = 4'd0,
    AM_ABSX   = 4'd1,
    AM_ABSY   = 4'd2,
    AM_ZP     = 4'd3,
    AM_ZPX    = 4'd4,
    AM_ZPY    = 4'd5,
    AM_IABS   = 4'd6,
    AM_IABSX  = 4'd7,
    AM_IABSY  = 4'd8,
    AM_IZP    = 4'd9,
    AM_IZPX   = 4'd10,
    AM_IZPY   = 4'd11,
    AM_IZP_PX = 4'd12,
    AM_IZP_PY = 4'd13,
    AM_PCREL  = 4'd14,
    AM_SPREL  = 4'd15
  } amode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_DONE} fst_t;

  function automatic logic [EA_W-1:0] zext(input logic [BYTE_W-1:0] b);
    return {{(EA_W-BYTE_W){1'b0}}, b};
  endfunction

  function automatic logic [EA_W-1:0] sext(input logic [BYTE_W-1:0] b);
    return {{(EA_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [EA_W-1:0] zp_sum(input logic [BYTE_W-1:0] base,
                                             input logic [BYTE_W-1:0] idx);
    logic [BYTE_W-1:0] s;
    s = base + idx;
    return zext(s);
  endfunction

  function automatic logic [EA_W-1:0] rel_sum(input logic [EA_W-1:0] base,
                                              input logic [BYTE_W-1:0] off);
    return base + sext(off);
  endfunction

  function automatic logic is_indirect(input amode_t m);
    return (m >= AM_IABS) && (m <= AM_IZP_PY);
  endfunction

  function automatic logic ptr_in_zp(input amode_t m);
    return (m >= AM_IZP) && (m <= AM_IZP_PY);
  endfunction

  function automatic logic [EA_W-1:0] next_ptr(input logic [EA_W-1:0] a,
                                               input logic zp);
    logic [BYTE_W-1:0] lo1;
    lo1 = a[BYTE_W-1:0] + 1'b1;
    return zp ? zext(lo1) : a + 1'b1;
  endfunction
endpackage

// File: rtl/oea_calc.sv
module oea_calc
  import oea_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  amode_t             mode,
  input  logic [EA_W-1:0]    opnd,
  input  logic [BYTE_W-1:0]  x_val,
  input  logic [BYTE_W-1:0]  y_val,
  input  logic [EA_W-1:0]    pc_val,
  input  logic [BYTE_W-1:0]  sp_val,
  output logic [EA_W-1:0]    direct_ea,
  output logic [EA_W-1:0]    ptr_lo_addr,
  output logic [EA_W-1:0]    ptr_hi_addr,
  output logic [BYTE_W-1:0]  post_add,
  output logic               indirect
);
  logic [BYTE_W-1:0] zp_op;
  assign zp_op = opnd[BYTE_W-1:0];

  always_comb begin
    direct_ea   = '0;
    ptr_lo_addr = '0;
    post_add    = '0;
    unique case (mode)
      AM_ABS:    direct_ea = opnd;
      AM_ABSX:   direct_ea = opnd + zext(x_val);
      AM_ABSY:   direct_ea = opnd + zext(y_val);
      AM_ZP:     direct_ea = zext(zp_op);
      AM_ZPX:    direct_ea = zp_sum(zp_op, x_val);
      AM_ZPY:    direct_ea = zp_sum(zp_op, y_val);
      AM_IABS:   ptr_lo_addr = opnd;
      AM_IABSX:  ptr_lo_addr = opnd + zext(x_val);
      AM_IABSY:  ptr_lo_addr = opnd + zext(y_val);
      AM_IZP:    ptr_lo_addr = zext(zp_op);
      AM_IZPX:   ptr_lo_addr = zp_sum(zp_op, x_val);
      AM_IZPY:   ptr_lo_addr = zp_sum(zp_op, y_val);
      AM_IZP_PX: begin ptr_lo_addr = zext(zp_op); post_add = x_val; end
      AM_IZP_PY: begin ptr_lo_addr = zext(zp_op); post_add = y_val; end
      AM_PCREL:  direct_ea = rel_sum(pc_val, zp_op);
      AM_SPREL:  direct_ea = rel_sum({STACK_PAGE, sp_val}, zp_op);
      default:   direct_ea = '0;
    endcase
  end

  assign indirect    = is_indirect(mode);
  assign ptr_hi_addr = next_ptr(ptr_lo_addr, ptr_in_zp(mode));
endmodule

// File: rtl/oea_fsm.sv
module oea_fsm
  import oea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_ptr,
  input  logic mem_ack,
  output logic accept,
  output logic lo_phase,
  output logic hi_phase,
  output logic lo_take,
  output logic hi_take,
  output logic done,
  output logic busy
);
  fst_t st_q, st_d;

  assign accept   = start && (st_q == ST_IDLE);
  assign lo_phase = (st_q == ST_LO);
  assign hi_phase = (st_q == ST_HI);
  assign lo_take  = lo_phase && mem_ack;
  assign hi_take  = hi_phase && mem_ack;
  assign done     = (st_q == ST_DONE);
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = need_ptr ? ST_LO : ST_DONE;
      ST_LO:   if (mem_ack) st_d = ST_HI;
      ST_HI:   if (mem_ack) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/oea_dpath.sv
module oea_dpath
  import oea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              need_ptr,
  input  logic [EA_W-1:0]   c_direct,
  input  logic [EA_W-1:0]   c_plo,
  input  logic [EA_W-1:0]   c_phi,
  input  logic [BYTE_W-1:0] c_post,
  input  logic              lo_take,
  input  logic              hi_take,
  input  logic              hi_phase,
  input  logic [BYTE_W-1:0] rdata,
  output logic [EA_W-1:0]   ea,
  output logic [EA_W-1:0]   fetch_addr
);
  logic [EA_W-1:0]   plo_q, phi_q, ea_q;
  logic [BYTE_W-1:0] post_q, lo_byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plo_q     <= '0;
      phi_q     <= '0;
      post_q    <= '0;
      lo_byte_q <= '0;
      ea_q      <= '0;
    end else begin
      if (accept) begin
        plo_q  <= c_plo;
        phi_q  <= c_phi;
        post_q <= c_post;
        if (!need_ptr) ea_q <= c_direct;
      end
      if (lo_take) lo_byte_q <= rdata;
      if (hi_take) ea_q <= {rdata, lo_byte_q} + zext(post_q);
    end
  end

  assign ea         = ea_q;
  assign fetch_addr = hi_phase ? phi_q : plo_q;
endmodule

// File: rtl/oea_unit.sv
module oea_unit
  import oea_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [15:0] operand,
  input  logic [7:0]  x_reg,
  input  logic [7:0]  y_reg,
  input  logic [15:0] pc_next,
  input  logic [7:0]  sp_reg,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic [15:0] ea,
  output logic        busy
);
  logic [EA_W-1:0]   c_direct, c_plo, c_phi;
  logic [BYTE_W-1:0] c_post;
  logic              c_ind;
  logic              accept, lo_phase, hi_phase, lo_take, hi_take;

  oea_calc #(.STACK_PAGE(STACK_PAGE)) u_calc (
    .mode(amode_t'(mode)), .opnd(operand), .x_val(x_reg), .y_val(y_reg),
    .pc_val(pc_next), .sp_val(sp_reg), .direct_ea(c_direct),
    .ptr_lo_addr(c_plo), .ptr_hi_addr(c_phi), .post_add(c_post),
    .indirect(c_ind)
  );

  oea_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .need_ptr(c_ind),
    .mem_ack(mem_ack), .accept(accept), .lo_phase(lo_phase),
    .hi_phase(hi_phase), .lo_take(lo_take), .hi_take(hi_take),
    .done(done), .busy(busy)
  );

  oea_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .need_ptr(c_ind),
    .c_direct(c_direct), .c_plo(c_plo), .c_phi(c_phi), .c_post(c_post),
    .lo_take(lo_take), .hi_take(hi_take), .hi_phase(hi_phase),
    .rdata(mem_rdata), .ea(ea), .fetch_addr(mem_addr)
  );

  assign mem_req = lo_phase || hi_phase;
endmodule

// File: rtl/oea_unit_chk.sv
module oea_unit_chk
  import oea_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic        hi_take
);
  // R2: a direct mode finishes in the next cycle without touching memory
  a_r2_direct_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !is_indirect(amode_t'(mode))) |=> (done && !mem_req));

  // R10: request and address held until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: high-byte acknowledge leads to done in the next cycle
  a_r10_done_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    hi_take |=> done);

  // R11: an idle block neither requests memory nor reports done
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  // R6: an indirect start leads to a memory request in the next cycle
  a_r6_fetch_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && is_indirect(amode_t'(mode))) |=> (mem_req && !done));
endmodule

bind oea_unit oea_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .done(done), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .hi_take(hi_take)
);

// File: tb/oea_unit_tb_top.sv
`timescale 1ns/1ps
module oea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] operand = '0;
  logic [7:0]  x_reg = '0, y_reg = '0, sp_reg = '0;
  logic [15:0] pc_next = '0;
  logic        mem_req, done, busy;
  logic [15:0] mem_addr, ea;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0, fails = 0;
  int lat = 0, wcnt = 0;
  int log_n = 0;
  logic [15:0] addr_log [4];
  int done_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  oea_unit dut_i (.*);

  function automatic logic [7:0] mval(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory responder, falling-edge driven
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = mval(mem_addr);
        if (log_n < 4) addr_log[log_n] = mem_addr;
        log_n++;
      end else wcnt++;
    end
  end

  always @(posedge clk) if (done) done_cnt++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // run one request; returns result and cycles from start edge to done seen
  task automatic run(input logic [3:0] m, input logic [15:0] op, input logic [7:0] xv,
                     input logic [7:0] yv, input logic [15:0] pcv, input logic [7:0] spv,
                     output logic [15:0] res, output int cyc);
    @(negedge clk);
    mode = m; operand = op; x_reg = xv; y_reg = yv; pc_next = pcv; sp_reg = spv;
    start = 1'b1; log_n = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    res = ea;
    @(negedge clk);
  endtask

  task automatic direct_case(input string tag, input logic [3:0] m, input logic [15:0] op,
                             input logic [7:0] xv, input logic [7:0] yv,
                             input logic [15:0] pcv, input logic [7:0] spv,
                             input logic [15:0] exp);
    logic [15:0] r; int c;
    run(m, op, xv, yv, pcv, spv, r, c);
    check(tag, r, exp);
    check({tag, " latency"}, 16'(c), 16'd1);
    check({tag, " no mem"}, 16'(log_n), 16'd0);
  endtask

  task automatic ind_case(input string tag, input logic [3:0] m, input logic [15:0] op,
                          input logic [7:0] xv, input logic [7:0] yv,
                          input logic [15:0] la, input logic [15:0] ha, input logic [7:0] post);
    logic [15:0] r; int c; logic [15:0] exp;
    run(m, op, xv, yv, 16'h0, 8'h0, r, c);
    exp = {mval(ha), mval(la)} + {8'h00, post};
    check({tag, " ea"}, r, exp);
    check({tag, " reads"}, 16'(log_n), 16'd2);
    check({tag, " lo addr"}, addr_log[0], la);
    check({tag, " hi addr"}, addr_log[1], ha);
    check({tag, " one done (R10)"}, 16'(done_cnt), 16'd1);
  endtask

  task automatic t_reset;
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 mem_req", {15'd0, mem_req}, 16'd0);
    check("R1 busy", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_absolute;
    direct_case("R2 abs", 4'd0, 16'h2400, 8'h11, 8'h22, 16'h0, 8'h0, 16'h2400);
    direct_case("R2 abs+x wrap", 4'd1, 16'hFFF0, 8'h20, 8'h00, 16'h0, 8'h0, 16'h0010);
    direct_case("R2 abs+y", 4'd2, 16'h12FF, 8'h00, 8'h01, 16'h0, 8'h0, 16'h1300);
  endtask

  task automatic t_zero_page;
    direct_case("R3 zp", 4'd3, 16'h12AB, 8'h00, 8'h00, 16'h0, 8'h0, 16'h00AB);
    direct_case("R3 zp+x wrap", 4'd4, 16'h00F0, 8'h20, 8'h00, 16'h0, 8'h0, 16'h0010);
    direct_case("R3 zp+y", 4'd5, 16'h0024, 8'h00, 8'h10, 16'h0, 8'h0, 16'h0034);
  endtask

  task automatic t_pc_rel;
    direct_case("R4 pc fwd", 4'd14, 16'h0024, 8'h0, 8'h0, 16'h1000, 8'h0, 16'h1024);
    direct_case("R4 pc back", 4'd14, 16'h00FE, 8'h0, 8'h0, 16'h1000, 8'h0, 16'h0FFE);
    direct_case("R4 pc wrap", 4'd14, 16'h007F, 8'h0, 8'h0, 16'hFFF0, 8'h0, 16'h006F);
  endtask

  task automatic t_sp_rel;
    direct_case("R5 sp fwd", 4'd15, 16'h0024, 8'h0, 8'h0, 16'h0, 8'h80, 16'h01A4);
    direct_case("R5 sp back", 4'd15, 16'h00FE, 8'h0, 8'h0, 16'h0, 8'h80, 16'h017E);
    direct_case("R5 sp below page", 4'd15, 16'h0080, 8'h0, 8'h0, 16'h0, 8'h10, 16'h0090);
  endtask

  task automatic t_indirect_abs;
    lat = 0;
    ind_case("R6 (abs)", 4'd6, 16'h2400, 8'h0, 8'h0, 16'h2400, 16'h2401, 8'h00);
    ind_case("R6 (abs) at FFFF", 4'd6, 16'hFFFF, 8'h0, 8'h0, 16'hFFFF, 16'h0000, 8'h00);
  endtask

  task automatic t_zp_ptr_wrap;
    ind_case("R7 (zp) at FF", 4'd9, 16'h00FF, 8'h0, 8'h0, 16'h00FF, 16'h0000, 8'h00);
  endtask

  task automatic t_pre_index;
    ind_case("R8 (zp,x) wrap", 4'd10, 16'h00F0, 8'h0F, 8'h0, 16'h00FF, 16'h0000, 8'h00);
    ind_case("R8 (zp,y)", 4'd11, 16'h0040, 8'h0, 8'h12, 16'h0052, 16'h0053, 8'h00);
    ind_case("R8 (abs,x)", 4'd7, 16'h30F0, 8'h20, 8'h0, 16'h3110, 16'h3111, 8'h00);
    ind_case("R8 (abs,y)", 4'd8, 16'h3000, 8'h0, 8'h7F, 16'h307F, 16'h3080, 8'h00);
  endtask

  task automatic t_post_index;
    lat = 2;
    ind_case("R9 (zp),x", 4'd12, 16'h0033, 8'hF0, 8'h05, 16'h0033, 16'h0034, 8'hF0);
    ind_case("R9 (zp),y", 4'd13, 16'h00FF, 8'h05, 8'hC8, 16'h00FF, 16'h0000, 8'hC8);
    lat = 0;
  endtask

  task automatic t_busy_ignore;
    logic [15:0] exp;
    lat = 3;
    @(negedge clk);
    mode = 4'd12; operand = 16'h0050; x_reg = 8'h44; y_reg = 8'h0;
    start = 1'b1; log_n = 0; done_cnt = 0;
    @(negedge clk);
    mode = 4'd0; operand = 16'hBEEF; x_reg = 8'h99;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    exp = {mval(16'h0051), mval(16'h0050)} + 16'h0044;
    check("R11 ea from first request", ea, exp);
    check("R11 single done", 16'(done_cnt), 16'd1);
    check("R11 idle after", {15'd0, busy}, 16'd0);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_absolute;
    t_zero_page;
    t_pc_rel;
    t_sp_rel;
    t_indirect_abs;
    t_zp_ptr_wrap;
    t_pre_index;
    t_post_index;
    t_busy_ignore;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule